// File: doc/BRIEF.md
# Sixteen-Channel Capture/Compare Timer Unit

This block provides two free-running 16-bit timers that sixteen event channels share. Each timer advances on one of three clock sources: a tick from a common prescaler on the module clock, a rising edge on a dedicated timer pin, or the wrap of the other timer. When a timer wraps past its all-ones value it reloads from its own reload value and emits a one-cycle wrap pulse.

Every channel owns a 16-bit register and a selector that binds it to either timer. In capture mode, a chosen edge on the channel pin stores the bound timer's count into the register. In compare mode, the timer stepping onto the register value either sets or toggles the channel output. Both capture and compare events raise a one-cycle request pulse on that channel. Channel registers are loaded through a simple write port. The configuration inputs are expected to be driven by surrounding control logic.

Top module: `capcmp_unit`

## Requirements
- R1: The prescaler counts module clocks and issues a tick on every cycle in which its count equals `presc_div`, then restarts from zero, so a tick comes every `presc_div`+1 cycles. A timer whose source code is 0 (prescaled) advances by one per tick.
- R2: A running timer at 0xFFFF that receives an advance loads its reload value instead, and `tmr_irq` for that timer is high for exactly the cycle in which the reloaded count is first visible.
- R3: A timer whose `tmr_run` bit is low keeps its count unchanged.
- R4: A timer with source code 1 (pin) advances once per rising edge of its `tmr_pin` bit. The pin passes two synchronizing flops and an edge flop, so the count changes on the third clock edge after the pin rises.
- R5: A timer with source code 2 (cascade) advances on the clock edge that ends the other timer's `tmr_irq` pulse.
- R6: In capture mode (mode code 1), the channel's 2-bit edge field selects the trigger: bit 0 set arms rising edges, bit 1 set arms falling edges, and 0 arms none. The pin passes the same three-flop chain as in R4.
- R7: A capture stores the bound timer's count (`ch_tsel` 0 means timer 0, 1 means timer 1), as it was in the cycle the edge was detected, into the channel register. The channel's `ch_irq` is pulsed for one cycle together with the new value.
- R8: A write (`wr_en` with `wr_ch` selecting the channel) loads `wr_data` into the register one cycle later. A capture in the same cycle wins over the write.
- R9: In compare mode, a match happens when the bound timer has just stepped and its new count equals the channel register. Mode 2 then drives `cc_out` high, mode 3 inverts it, and either mode pulses `ch_irq` for one cycle, on the edge after the step.
- R10: A timer that holds its count between prescaler ticks produces no further matches. Exactly one match occurs per step onto the value.
- R11: In mode 0 (off), the channel output is cleared on the next edge and no request is raised.
- R12: Synchronous active-high reset clears the timers, the prescaler, every channel register, every output and every request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| presc_div | input | 4 | Prescaler terminal count |
| tmr_run | input | 2 | Run enable per timer |
| tmr_src | input | 4 | Clock source per timer, 2 bits each: 0 prescaled, 1 pin, 2 cascade |
| tmr_reload | input | 32 | Reload value per timer, 16 bits each |
| tmr_pin | input | 2 | External count input per timer |
| ch_mode | input | 32 | Mode per channel, 2 bits each: 0 off, 1 capture, 2 compare-set, 3 compare-toggle |
| ch_tsel | input | 16 | Timer binding per channel |
| ch_edge | input | 32 | Capture edge arming per channel, 2 bits each |
| cap_pin | input | 16 | Capture event input per channel |
| wr_en | input | 1 | Channel register write strobe |
| wr_ch | input | 4 | Channel index of the write |
| wr_data | input | 16 | Write value |
| tmr_cnt | output | 32 | Current count per timer |
| tmr_irq | output | 2 | Wrap pulse per timer |
| ch_val | output | 256 | Channel registers, 16 bits each |
| cc_out | output | 16 | Compare output per channel |
| ch_irq | output | 16 | Request pulse per channel |

## Verification
The checks that run on every cycle cover the following: the reload value appearing with each wrap pulse, timers holding while stopped, requests only from enabled channels, a capture request carrying the bound timer's earlier count, the output clearing in the off mode, and every output rise coming with a request. Other behaviours need the bench's scenarios and its cycle model. These are the exact prescaler spacing, the latency of the synchronizer chain, the cascade timing, the edge arming codes, capture winning over a same-cycle write, and the single match per step of a slowly ticking timer.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;

    localparam int NUM_TMR = 2;

    typedef enum logic [1:0] {
        SRC_PRESC   = 2'd0,
        SRC_PIN     = 2'd1,
        SRC_CASCADE = 2'd2
    } tmr_src_e;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'd0,
        MODE_CAPTURE = 2'd1,
        MODE_CMP_SET = 2'd2,
        MODE_CMP_TGL = 2'd3
    } ch_mode_e;

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } pin_sync_t;

    function automatic logic edge_hit(input logic [1:0] arm, input pin_sync_t ps);
        logic rise;
        logic fall;
        rise = ps.s2 & ~ps.prev;
        fall = ~ps.s2 & ps.prev;
        return (arm[0] & rise) | (arm[1] & fall);
    endfunction

    function automatic pin_sync_t sync_step(input pin_sync_t ps, input logic pin);
        pin_sync_t n;
        n.s1   = pin;
        n.s2   = ps.s1;
        n.prev = ps.s2;
        return n;
    endfunction

endpackage

// File: rtl/capcmp_prescaler.sv
module capcmp_prescaler #(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] div,
    output logic          tick
);
    logic [PW-1:0] cnt_q;

    assign tick = (cnt_q == div);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
    import capcmp_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  tmr_src_e      src,
    input  logic          presc_tick,
    input  logic          casc_in,
    input  logic          pin,
    input  logic [TW-1:0] reload,
    output logic [TW-1:0] cnt,
    output logic          ovf,
    output logic          step
);
    pin_sync_t ps_q;
    logic      adv;
    logic      src_pulse;

    always_comb begin
        unique case (src)
            SRC_PRESC:   src_pulse = presc_tick;
            SRC_PIN:     src_pulse = edge_hit(2'b01, ps_q);
            SRC_CASCADE: src_pulse = casc_in;
            default:     src_pulse = 1'b0;
        endcase
        adv = run & src_pulse;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ps_q <= '0;
            cnt  <= '0;
            ovf  <= 1'b0;
            step <= 1'b0;
        end else begin
            ps_q <= sync_step(ps_q, pin);
            step <= adv;
            ovf  <= 1'b0;
            if (adv) begin
                if (cnt == {TW{1'b1}}) begin
                    cnt <= reload;
                    ovf <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/capcmp_channel.sv
module capcmp_channel
    import capcmp_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  ch_mode_e              mode,
    input  logic                  tsel,
    input  logic [1:0]            arm,
    input  logic                  pin,
    input  logic                  wr_hit,
    input  logic [TW-1:0]         wr_data,
    input  logic [NUM_TMR*TW-1:0] tmr_cnt,
    input  logic [NUM_TMR-1:0]    tmr_step,
    output logic [TW-1:0]         val,
    output logic                  out,
    output logic                  irq
);
    pin_sync_t     ps_q;
    logic [TW-1:0] sel_cnt;
    logic          sel_step;
    logic          cap_fire;
    logic          cmp_match;

    always_comb begin
        sel_cnt   = tsel ? tmr_cnt[TW +: TW] : tmr_cnt[0 +: TW];
        sel_step  = tsel ? tmr_step[1] : tmr_step[0];
        cap_fire  = (mode == MODE_CAPTURE) && edge_hit(arm, ps_q);
        cmp_match = sel_step && (sel_cnt == val);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ps_q <= '0;
            val  <= '0;
            out  <= 1'b0;
            irq  <= 1'b0;
        end else begin
            ps_q <= sync_step(ps_q, pin);
            irq  <= 1'b0;
            if (cap_fire) begin
                val <= sel_cnt;
                irq <= 1'b1;
            end else if (wr_hit) begin
                val <= wr_data;
            end
            unique case (mode)
                MODE_OFF: out <= 1'b0;
                MODE_CMP_SET: begin
                    if (cmp_match) begin
                        out <= 1'b1;
                        irq <= 1'b1;
                    end
                end
                MODE_CMP_TGL: begin
                    if (cmp_match) begin
                        out <= ~out;
                        irq <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/capcmp_unit.sv
module capcmp_unit
    import capcmp_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int TW     = 16,
    parameter int PW     = 4,
    localparam int CH_AW = $clog2(NUM_CH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PW-1:0]        presc_div,
    input  logic [NUM_TMR-1:0]   tmr_run,
    input  logic [2*NUM_TMR-1:0] tmr_src,
    input  logic [NUM_TMR*TW-1:0] tmr_reload,
    input  logic [NUM_TMR-1:0]   tmr_pin,
    input  logic [2*NUM_CH-1:0]  ch_mode,
    input  logic [NUM_CH-1:0]    ch_tsel,
    input  logic [2*NUM_CH-1:0]  ch_edge,
    input  logic [NUM_CH-1:0]    cap_pin,
    input  logic                 wr_en,
    input  logic [CH_AW-1:0]     wr_ch,
    input  logic [TW-1:0]        wr_data,
    output logic [NUM_TMR*TW-1:0] tmr_cnt,
    output logic [NUM_TMR-1:0]   tmr_irq,
    output logic [NUM_CH*TW-1:0] ch_val,
    output logic [NUM_CH-1:0]    cc_out,
    output logic [NUM_CH-1:0]    ch_irq
);
    logic               presc_tick;
    logic [NUM_TMR-1:0] tmr_step;

    capcmp_prescaler #(.PW(PW)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .div  (presc_div),
        .tick (presc_tick)
    );

    for (genvar k = 0; k < NUM_TMR; k++) begin : g_tmr
        capcmp_timer #(.TW(TW)) u_tmr (
            .clk        (clk),
            .rst        (rst),
            .run        (tmr_run[k]),
            .src        (tmr_src_e'(tmr_src[2*k +: 2])),
            .presc_tick (presc_tick),
            .casc_in    (tmr_irq[NUM_TMR-1-k]),
            .pin        (tmr_pin[k]),
            .reload     (tmr_reload[TW*k +: TW]),
            .cnt        (tmr_cnt[TW*k +: TW]),
            .ovf        (tmr_irq[k]),
            .step       (tmr_step[k])
        );
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic wr_hit;
        assign wr_hit = wr_en && (wr_ch == CH_AW'(i));

        capcmp_channel #(.TW(TW)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .mode     (ch_mode_e'(ch_mode[2*i +: 2])),
            .tsel     (ch_tsel[i]),
            .arm      (ch_edge[2*i +: 2]),
            .pin      (cap_pin[i]),
            .wr_hit   (wr_hit),
            .wr_data  (wr_data),
            .tmr_cnt  (tmr_cnt),
            .tmr_step (tmr_step),
            .val      (ch_val[TW*i +: TW]),
            .out      (cc_out[i]),
            .irq      (ch_irq[i])
        );
    end
endmodule

// File: rtl/capcmp_checker.sv
module capcmp_checker #(
    parameter int NUM_CH = 16,
    parameter int TW     = 16
) (
    input logic                clk,
    input logic                rst,
    input logic [1:0]          tmr_run,
    input logic [2*TW-1:0]     tmr_reload,
    input logic [2*NUM_CH-1:0] ch_mode,
    input logic [NUM_CH-1:0]   ch_tsel,
    input logic [2*TW-1:0]     tmr_cnt,
    input logic [1:0]          tmr_irq,
    input logic [NUM_CH*TW-1:0] ch_val,
    input logic [NUM_CH-1:0]   cc_out,
    input logic [NUM_CH-1:0]   ch_irq
);
    for (genvar k = 0; k < 2; k++) begin : g_t
        assert_reload_on_wrap_R2: assert property (@(posedge clk) disable iff (rst)
            tmr_irq[k] |-> tmr_cnt[TW*k +: TW] == $past(tmr_reload[TW*k +: TW]));

        assert_stopped_holds_R3: assert property (@(posedge clk) disable iff (rst)
            !tmr_run[k] |=> $stable(tmr_cnt[TW*k +: TW]));
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_c
        assert_off_no_request_R11: assert property (@(posedge clk) disable iff (rst)
            ch_irq[i] |-> $past(ch_mode[2*i +: 2]) != 2'd0);

        assert_off_clears_out_R11: assert property (@(posedge clk) disable iff (rst)
            $past(ch_mode[2*i +: 2]) == 2'd0 |-> !cc_out[i]);

        assert_capture_value_R7: assert property (@(posedge clk) disable iff (rst)
            (ch_irq[i] && $past(ch_mode[2*i +: 2]) == 2'd1) |->
            ch_val[TW*i +: TW] == $past(ch_tsel[i] ? tmr_cnt[TW +: TW] : tmr_cnt[0 +: TW]));

        assert_out_rise_requests_R9: assert property (@(posedge clk) disable iff (rst)
            $rose(cc_out[i]) |-> ch_irq[i]);
    end
endmodule

bind capcmp_unit capcmp_checker #(.NUM_CH(NUM_CH), .TW(TW)) u_capcmp_chk (
    .clk        (clk),
    .rst        (rst),
    .tmr_run    (tmr_run),
    .tmr_reload (tmr_reload),
    .ch_mode    (ch_mode),
    .ch_tsel    (ch_tsel),
    .tmr_cnt    (tmr_cnt),
    .tmr_irq    (tmr_irq),
    .ch_val     (ch_val),
    .cc_out     (cc_out),
    .ch_irq     (ch_irq)
);

// File: tb/test_capcmp_unit.sv
`timescale 1ns/1ps
module test_capcmp_unit;
    localparam int NCH = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   presc_div = '0;
    logic [1:0]   tmr_run = '0;
    logic [3:0]   tmr_src = '0;
    logic [31:0]  tmr_reload = '0;
    logic [1:0]   tmr_pin = '0;
    logic [31:0]  ch_mode = '0;
    logic [15:0]  ch_tsel = '0;
    logic [31:0]  ch_edge = '0;
    logic [15:0]  cap_pin = '0;
    logic         wr_en = 1'b0;
    logic [3:0]   wr_ch = '0;
    logic [15:0]  wr_data = '0;
    logic [31:0]  tmr_cnt;
    logic [1:0]   tmr_irq;
    logic [255:0] ch_val;
    logic [15:0]  cc_out;
    logic [15:0]  ch_irq;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    capcmp_unit i_capcmp_unit (
        .clk(clk), .rst(rst), .presc_div(presc_div), .tmr_run(tmr_run),
        .tmr_src(tmr_src), .tmr_reload(tmr_reload), .tmr_pin(tmr_pin),
        .ch_mode(ch_mode), .ch_tsel(ch_tsel), .ch_edge(ch_edge),
        .cap_pin(cap_pin), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
        .tmr_cnt(tmr_cnt), .tmr_irq(tmr_irq), .ch_val(ch_val),
        .cc_out(cc_out), .ch_irq(ch_irq)
    );

    // ---------------- behavioural reference ----------------
    int          m_presc;
    logic [15:0] m_cnt [2];
    bit          m_ovf [2];
    bit          m_step [2];
    bit          t_s1 [2], t_s2 [2], t_pv [2];
    logic [15:0] m_val [NCH];
    bit          m_out [NCH];
    bit          m_irq [NCH];
    bit          c_s1 [NCH], c_s2 [NCH], c_pv [NCH];

    always @(posedge clk) begin
        logic [15:0] n_cnt [2];
        bit          n_ovf [2];
        bit          n_step [2];
        logic [15:0] n_val [NCH];
        bit          n_out [NCH];
        bit          n_irq [NCH];
        bit          tick;
        if (rst) begin
            m_presc = 0;
            for (int k = 0; k < 2; k++) begin
                m_cnt[k] = '0; m_ovf[k] = 0; m_step[k] = 0;
                t_s1[k] = 0; t_s2[k] = 0; t_pv[k] = 0;
            end
            for (int i = 0; i < NCH; i++) begin
                m_val[i] = '0; m_out[i] = 0; m_irq[i] = 0;
                c_s1[i] = 0; c_s2[i] = 0; c_pv[i] = 0;
            end
        end else begin
            tick = (m_presc == int'(presc_div));
            for (int k = 0; k < 2; k++) begin
                bit inc;
                case (tmr_src[2*k +: 2])
                    2'd0: inc = tick;
                    2'd1: inc = t_s2[k] && !t_pv[k];
                    2'd2: inc = m_ovf[1-k];
                    default: inc = 0;
                endcase
                inc = inc && tmr_run[k];
                n_step[k] = inc; n_ovf[k] = 0; n_cnt[k] = m_cnt[k];
                if (inc) begin
                    if (m_cnt[k] == 16'hFFFF) begin
                        n_cnt[k] = tmr_reload[16*k +: 16]; n_ovf[k] = 1;
                    end else n_cnt[k] = m_cnt[k] + 16'd1;
                end
            end
            for (int i = 0; i < NCH; i++) begin
                int  sel;
                bit  hit, match;
                logic [1:0] md, ar;
                sel = int'(ch_tsel[i]);
                md = ch_mode[2*i +: 2];
                ar = ch_edge[2*i +: 2];
                hit = (ar[0] && c_s2[i] && !c_pv[i]) || (ar[1] && !c_s2[i] && c_pv[i]);
                match = m_step[sel] && (m_cnt[sel] == m_val[i]);
                n_val[i] = m_val[i]; n_out[i] = m_out[i]; n_irq[i] = 0;
                if (md == 2'd1 && hit) begin
                    n_val[i] = m_cnt[sel]; n_irq[i] = 1;
                end else if (wr_en && int'(wr_ch) == i) n_val[i] = wr_data;
                if (md == 2'd0) n_out[i] = 0;
                else if (md == 2'd2 && match) begin n_out[i] = 1; n_irq[i] = 1; end
                else if (md == 2'd3 && match) begin n_out[i] = !m_out[i]; n_irq[i] = 1; end
            end
            m_presc = tick ? 0 : (m_presc + 1) % 16;
            for (int k = 0; k < 2; k++) begin
                m_cnt[k] = n_cnt[k]; m_ovf[k] = n_ovf[k]; m_step[k] = n_step[k];
                t_pv[k] = t_s2[k]; t_s2[k] = t_s1[k]; t_s1[k] = tmr_pin[k];
            end
            for (int i = 0; i < NCH; i++) begin
                m_val[i] = n_val[i]; m_out[i] = n_out[i]; m_irq[i] = n_irq[i];
                c_pv[i] = c_s2[i]; c_s2[i] = c_s1[i]; c_s1[i] = cap_pin[i];
            end
        end
    end

    task automatic check(input string what, input logic [255:0] act, input logic [255:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%h expected=%h", what, $time, act, exp);
        end
    endtask

    // compare every cycle, 2 ns after the active edge
    always @(posedge clk) begin
        #2;
        if (!rst) begin
            logic [31:0]  e_cnt;
            logic [1:0]   e_tirq;
            logic [255:0] e_val;
            logic [15:0]  e_out, e_irq;
            for (int k = 0; k < 2; k++) begin
                e_cnt[16*k +: 16] = m_cnt[k];
                e_tirq[k] = m_ovf[k];
            end
            for (int i = 0; i < NCH; i++) begin
                e_val[16*i +: 16] = m_val[i];
                e_out[i] = m_out[i];
                e_irq[i] = m_irq[i];
            end
            check("tmr_cnt R1 R3 R4 R5", 256'(tmr_cnt), 256'(e_cnt));
            check("tmr_irq R2", 256'(tmr_irq), 256'(e_tirq));
            check("ch_val R6 R7 R8", ch_val, e_val);
            check("cc_out R9 R10 R11", 256'(cc_out), 256'(e_out));
            check("ch_irq R7 R9 R10 R11", 256'(ch_irq), 256'(e_irq));
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ch(input int i, input logic [1:0] md, input logic ts, input logic [1:0] ar);
        ch_mode[2*i +: 2] = md;
        ch_tsel[i] = ts;
        ch_edge[2*i +: 2] = ar;
    endtask

    task automatic write_ch(input int i, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = 4'(i); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic noisy_pins(input int n, input int every);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            if (c % every == 0) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                cap_pin = lfsr;
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
    end

    initial begin
        cyc(3);
        // R12: reset state
        check("reset tmr_cnt R12", 256'(tmr_cnt), '0);
        check("reset ch_val R12", ch_val, '0);
        check("reset cc_out R12", 256'(cc_out), '0);
        check("reset ch_irq R12", 256'({tmr_irq, ch_irq}), '0);

        // phase 1: slow prescaled timer 0, mixed channel modes
        presc_div  = 4'd2;
        tmr_reload = {16'h0000, 16'hFFF0};
        tmr_src    = 4'b0000;
        set_ch(0, 2'd1, 1'b0, 2'b01);   // capture rising (R6)
        set_ch(1, 2'd1, 1'b0, 2'b10);   // capture falling (R6)
        set_ch(2, 2'd1, 1'b0, 2'b11);   // capture both (R6)
        set_ch(3, 2'd1, 1'b0, 2'b00);   // no edge armed (R6)
        set_ch(4, 2'd2, 1'b0, 2'b00);   // compare set (R9)
        set_ch(5, 2'd3, 1'b0, 2'b00);   // compare toggle (R9 R10)
        set_ch(6, 2'd3, 1'b1, 2'b00);   // bound to stopped timer 1
        for (int i = 7; i < NCH; i++) set_ch(i, 2'd1, 1'(i % 2), 2'b11);
        rst = 1'b0;
        write_ch(4, 16'd5);
        write_ch(5, 16'd7);
        write_ch(6, 16'd0);
        tmr_run = 2'b01;
        noisy_pins(150, 3);
        // R3: stop and hold
        tmr_run = 2'b00;
        noisy_pins(30, 2);
        tmr_run = 2'b01;
        // R8: writes to channel 7 while its pin toggles every cycle
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_ch = 4'd7; wr_data = 16'h1000 + 16'(c);
            cap_pin[7] = ~cap_pin[7];
        end
        @(negedge clk);
        wr_en = 1'b0;

        // phase 2: fast timer 0 reaches wrap, timer 1 cascades (R2 R5)
        presc_div = 4'd0;
        tmr_src   = 4'b1000;
        tmr_run   = 2'b11;
        write_ch(5, 16'hFFF8);
        set_ch(8, 2'd2, 1'b1, 2'b00);
        write_ch(8, 16'd3);
        cyc(66000);
        noisy_pins(200, 5);

        // R4: pin-clocked timers
        tmr_src = 4'b0101;
        for (int c = 0; c < 60; c++) begin
            cyc(4);
            tmr_pin = tmr_pin ^ 2'(c % 3 == 0 ? 3 : 1);
        end
        cyc(5);

        // R11: switch compare channels off
        set_ch(4, 2'd0, 1'b0, 2'b00);
        set_ch(5, 2'd0, 1'b0, 2'b00);
        cyc(10);

        // R10: slow ticks, compare on a value inside the reload range
        tmr_src   = 4'b0000;
        presc_div = 4'd7;
        set_ch(5, 2'd3, 1'b0, 2'b00);
        write_ch(5, 16'hFFF4);
        set_ch(4, 2'd2, 1'b0, 2'b00);
        write_ch(4, 16'hFFFA);
        cyc(700);
        // R1: divider change mid-count
        presc_div = 4'd1;
        cyc(100);
        summary();
    end
endmodule